// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

A small fully associative translation buffer that turns a 32-bit virtual address into a physical address. Each entry describes two adjacent pages: an even half and an odd half. Each half has its own frame base, valid bit and dirty bit. The page size is variable. The entry's page mask is always widened by the 13 low bits, so the smallest entry spans two 4 KB pages. The address bit that picks the half moves upward as the mask grows.

Software loads entries through a one-cycle write port. The port carries an index and every field of the entry. A lookup is purely combinational. It takes an address, the current 8-bit address-space identifier and a read/write flag. It returns a physical address, a writable flag and one of four result codes. The result codes let the surrounding pipeline raise the right fault: no entry matched, the entry half is invalid, or a write hit a page that is not dirty.

Top module: `tlb_pair_lookup`

## Requirements
- R1: An entry takes part in a lookup only when its global bit is set or its stored ASID equals `lk_asid_i`.
- R2: The effective mask of an entry is `mask | 0x1FFF`. An entry hits only when its stored page number equals `lk_vaddr_i` with the effective-mask bits cleared.
- R3: The half is selected by the address bit under the highest set bit of the effective mask: odd when that bit is 1, even when it is 0. In `wr_valid_i` and `wr_dirty_i`, bit 0 belongs to the even half and bit 1 to the odd half.
- R4: When the hitting entry's selected half is not valid, the result is INVALID (code 2).
- R5: On a read, or on a write to a half whose dirty bit is set, the result is MATCH (code 0). The physical address is that half's frame base ORed with the address bits under `effective_mask >> 1`.
- R6: A write to a valid half whose dirty bit is clear gives DIRTY (code 3). In that case, and in every other non-MATCH case, the physical address and the writable flag are zero.
- R7: On a MATCH, the writable flag equals the selected half's dirty bit.
- R8: When no entry hits, the result is NOMATCH (code 1).
- R9: When several entries hit, the entry with the lowest index decides the result.
- R10: A lookup reflects the table contents combinationally. A write becomes visible only after the next rising clock edge.
- R11: Reset clears every field of every entry to zero, valid bits included. After reset, a lookup of address 0 with ASID 0 therefore gives INVALID, and any address at or above 0x2000 gives NOMATCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write the entry selected by `wr_idx_i` on this edge |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_vpn_i | input | 32 | Virtual page-pair number (address with mask bits clear) |
| wr_mask_i | input | 32 | Page mask; the 13 low bits are always added |
| wr_global_i | input | 1 | Entry ignores the ASID |
| wr_asid_i | input | 8 | Address-space identifier of the entry |
| wr_pfn_even_i | input | 32 | Physical frame base of the even half |
| wr_pfn_odd_i | input | 32 | Physical frame base of the odd half |
| wr_valid_i | input | 2 | Valid bits, bit 0 even, bit 1 odd |
| wr_dirty_i | input | 2 | Dirty (write-enable) bits, bit 0 even, bit 1 odd |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| lk_asid_i | input | 8 | Current address-space identifier |
| lk_write_i | input | 1 | Access is a write |
| lk_paddr_o | output | 32 | Translated physical address, zero unless MATCH |
| lk_result_o | output | 2 | 0 MATCH, 1 NOMATCH, 2 INVALID, 3 DIRTY |
| lk_writable_o | output | 1 | Writes to the page are permitted |

## Verification
The three lookup outputs depend only on the lookup inputs and the stored table, so they are due in the same cycle as the inputs. The bench drives them after a falling edge and samples one nanosecond later, well before the next rising edge. Table writes are applied at a falling edge and complete at the following rising edge. The bench checks once before that edge, expecting the old contents, and once after it, expecting the new ones. Only after the edge does it update its own arithmetic model of the table.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;
  localparam int unsigned VA_W      = 32;
  localparam int unsigned ASID_W    = 8;
  localparam int unsigned MIN_PAIR_BITS = 13;
  localparam logic [VA_W-1:0] MIN_MASK = VA_W'((64'd1 << MIN_PAIR_BITS) - 1);

  typedef enum logic [1:0] {
    TLB_MATCH   = 2'd0,
    TLB_NOMATCH = 2'd1,
    TLB_INVALID = 2'd2,
    TLB_DIRTY   = 2'd3
  } tlb_result_e;

  typedef struct packed {
    logic [VA_W-1:0]   vpn;
    logic [VA_W-1:0]   mask;
    logic              glob;
    logic [ASID_W-1:0] asid;
    logic [VA_W-1:0]   pfn_even;
    logic [VA_W-1:0]   pfn_odd;
    logic [1:0]        valid;
    logic [1:0]        dirty;
  } tlb_entry_t;

  // per-entry candidate after half selection
  typedef struct packed {
    logic            hit;
    logic            valid;
    logic            dirty;
    logic [VA_W-1:0] pfn;
    logic [VA_W-1:0] off_mask;
  } tlb_cand_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pair_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned IDX_W       = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  tlb_entry_t                   wr_entry_i,
  output tlb_entry_t [NUM_ENTRIES-1:0] entries_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entries_o[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        entries_o[g] <= wr_entry_i;
      end
    end
  end
endmodule

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_pair_pkg::*;
(
  input  tlb_entry_t        entry_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [ASID_W-1:0] asid_i,
  output tlb_cand_t         cand_o
);
  logic [VA_W-1:0] eff_mask;
  logic [VA_W-1:0] half_mask;
  logic            asid_ok;
  logic            tag_ok;
  logic            odd;

  always_comb begin
    eff_mask  = entry_i.mask | MIN_MASK;
    half_mask = eff_mask >> 1;
    asid_ok   = entry_i.glob || (entry_i.asid == asid_i);
    tag_ok    = entry_i.vpn == (vaddr_i & ~eff_mask);
    odd       = |(vaddr_i & eff_mask & ~half_mask);

    cand_o.hit      = asid_ok && tag_ok;
    cand_o.valid    = odd ? entry_i.valid[1] : entry_i.valid[0];
    cand_o.dirty    = odd ? entry_i.dirty[1] : entry_i.dirty[0];
    cand_o.pfn      = odd ? entry_i.pfn_odd  : entry_i.pfn_even;
    cand_o.off_mask = half_mask;
  end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pair_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16
) (
  input  tlb_cand_t [NUM_ENTRIES-1:0] cand_i,
  input  logic [VA_W-1:0]             vaddr_i,
  input  logic                        write_i,
  output logic [VA_W-1:0]             paddr_o,
  output tlb_result_e                 result_o,
  output logic                        writable_o
);
  tlb_cand_t sel;
  logic      any_hit;

  // scan downward so the lowest hitting index is kept last
  always_comb begin
    sel     = '0;
    any_hit = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (cand_i[i].hit) begin
        sel     = cand_i[i];
        any_hit = 1'b1;
      end
    end
  end

  always_comb begin
    paddr_o    = '0;
    writable_o = 1'b0;
    if (!any_hit) begin
      result_o = TLB_NOMATCH;
    end else if (!sel.valid) begin
      result_o = TLB_INVALID;
    end else if (write_i && !sel.dirty) begin
      result_o = TLB_DIRTY;
    end else begin
      result_o   = TLB_MATCH;
      paddr_o    = sel.pfn | (vaddr_i & sel.off_mask);
      writable_o = sel.dirty;
    end
  end
endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
  import tlb_pair_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [31:0]       wr_vpn_i,
  input  logic [31:0]       wr_mask_i,
  input  logic              wr_global_i,
  input  logic [7:0]        wr_asid_i,
  input  logic [31:0]       wr_pfn_even_i,
  input  logic [31:0]       wr_pfn_odd_i,
  input  logic [1:0]        wr_valid_i,
  input  logic [1:0]        wr_dirty_i,
  input  logic [31:0]       lk_vaddr_i,
  input  logic [7:0]        lk_asid_i,
  input  logic              lk_write_i,
  output logic [31:0]       lk_paddr_o,
  output logic [1:0]        lk_result_o,
  output logic              lk_writable_o
);
  tlb_entry_t                   wr_entry;
  tlb_entry_t [NUM_ENTRIES-1:0] entries;
  tlb_cand_t  [NUM_ENTRIES-1:0] cands;
  tlb_result_e                  result;

  always_comb begin
    wr_entry.vpn      = wr_vpn_i;
    wr_entry.mask     = wr_mask_i;
    wr_entry.glob     = wr_global_i;
    wr_entry.asid     = wr_asid_i;
    wr_entry.pfn_even = wr_pfn_even_i;
    wr_entry.pfn_odd  = wr_pfn_odd_i;
    wr_entry.valid    = wr_valid_i;
    wr_entry.dirty    = wr_dirty_i;
  end

  tlb_entry_store #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) store_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_entry_i(wr_entry),
    .entries_o (entries)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
    tlb_entry_match match_i (
      .entry_i(entries[g]),
      .vaddr_i(lk_vaddr_i),
      .asid_i (lk_asid_i),
      .cand_o (cands[g])
    );
  end

  tlb_resolve #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) resolve_i (
    .cand_i    (cands),
    .vaddr_i   (lk_vaddr_i),
    .write_i   (lk_write_i),
    .paddr_o   (lk_paddr_o),
    .result_o  (result),
    .writable_o(lk_writable_o)
  );

  assign lk_result_o = result;
endmodule

// File: rtl/tlb_pair_lookup_chk.sv
module tlb_pair_lookup_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] lk_vaddr_i,
  input logic        lk_write_i,
  input logic [31:0] lk_paddr_o,
  input logic [1:0]  lk_result_o,
  input logic        lk_writable_o
);
  assert_no_xlat_on_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_result_o != 2'd0) |-> (lk_paddr_o == 32'd0 && !lk_writable_o));

  assert_writable_on_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_writable_o |-> (lk_result_o == 2'd0));

  assert_write_match_writable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_write_i && lk_result_o == 2'd0) |-> lk_writable_o);

  assert_read_never_dirty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_write_i |-> (lk_result_o != 2'd3));

  assert_offset_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_result_o == 2'd0) |-> ((lk_paddr_o & lk_vaddr_i & 32'hFFF) == (lk_vaddr_i & 32'hFFF)));
endmodule

bind tlb_pair_lookup tlb_pair_lookup_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lk_vaddr_i   (lk_vaddr_i),
  .lk_write_i   (lk_write_i),
  .lk_paddr_o   (lk_paddr_o),
  .lk_result_o  (lk_result_o),
  .lk_writable_o(lk_writable_o)
);

// File: tb/tlb_pair_lookup_tb.sv
`timescale 1ns/1ps
module tlb_pair_lookup_tb_top;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_vpn = '0, wr_mask = '0, wr_pe = '0, wr_po = '0;
  logic wr_g = 1'b0;
  logic [7:0] wr_asid = '0;
  logic [1:0] wr_v = '0, wr_d = '0;
  logic [31:0] lk_va = '0;
  logic [7:0] lk_asid = '0;
  logic lk_wr = 1'b0;
  logic [31:0] lk_pa;
  logic [1:0] lk_res;
  logic lk_w;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_vpn [N];
  logic [31:0] m_mask[N];
  logic        m_g   [N];
  logic [7:0]  m_asid[N];
  logic [31:0] m_pe  [N];
  logic [31:0] m_po  [N];
  logic [1:0]  m_v   [N];
  logic [1:0]  m_d   [N];

  always #2 clk = ~clk;

  tlb_pair_lookup #(.NUM_ENTRIES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vpn_i(wr_vpn), .wr_mask_i(wr_mask),
    .wr_global_i(wr_g), .wr_asid_i(wr_asid), .wr_pfn_even_i(wr_pe), .wr_pfn_odd_i(wr_po),
    .wr_valid_i(wr_v), .wr_dirty_i(wr_d),
    .lk_vaddr_i(lk_va), .lk_asid_i(lk_asid), .lk_write_i(lk_wr),
    .lk_paddr_o(lk_pa), .lk_result_o(lk_res), .lk_writable_o(lk_w)
  );

  task automatic model(input logic [31:0] va, input logic [7:0] asid, input logic wr,
                       output logic [1:0] res, output logic [31:0] pa, output logic w);
    logic [31:0] em;
    logic odd, v, d;
    res = 2'd1; pa = '0; w = 1'b0;
    for (int i = 0; i < N; i++) begin
      em = m_mask[i] | 32'h1FFF;
      if ((m_g[i] || m_asid[i] == asid) && m_vpn[i] == (va & ~em)) begin
        odd = (va & em & ~(em >> 1)) != 0;
        v = m_v[i][odd];
        d = m_d[i][odd];
        if (!v) res = 2'd2;
        else if (wr && !d) res = 2'd3;
        else begin
          res = 2'd0;
          pa = (odd ? m_po[i] : m_pe[i]) | (va & (em >> 1));
          w = d;
        end
        return;
      end
    end
  endtask

  task automatic compare(input string tag, input logic [1:0] er, input logic [31:0] ep, input logic ew);
    n_chk++;
    if (lk_res !== er || lk_pa !== ep || lk_w !== ew) begin
      n_fail++;
      $display("FAIL %s va=%h asid=%h wr=%0d: got res=%0d pa=%h w=%0d, expected res=%0d pa=%h w=%0d",
               tag, lk_va, lk_asid, lk_wr, lk_res, lk_pa, lk_w, er, ep, ew);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic wr);
    @(negedge clk);
    lk_va = va; lk_asid = asid; lk_wr = wr;
    #1;
  endtask

  task automatic check_exp(input logic [31:0] va, input logic [7:0] asid, input logic wr,
                           input logic [1:0] er, input logic [31:0] ep, input logic ew, input string tag);
    look(va, asid, wr);
    compare(tag, er, ep, ew);
  endtask

  task automatic check_model(input logic [31:0] va, input logic [7:0] asid, input logic wr, input string tag);
    logic [1:0] er; logic [31:0] ep; logic ew;
    look(va, asid, wr);
    model(va, asid, wr, er, ep, ew);
    compare(tag, er, ep, ew);
  endtask

  task automatic write_ent(input int idx, input logic [31:0] vpn, input logic [31:0] mask,
                           input logic g, input logic [7:0] asid, input logic [31:0] pe,
                           input logic [31:0] po, input logic [1:0] v, input logic [1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_vpn = vpn; wr_mask = mask; wr_g = g;
    wr_asid = asid; wr_pe = pe; wr_po = po; wr_v = v; wr_d = d;
    @(posedge clk);
    m_vpn[idx] = vpn; m_mask[idx] = mask; m_g[idx] = g; m_asid[idx] = asid;
    m_pe[idx] = pe; m_po[idx] = po; m_v[idx] = v; m_d[idx] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] base_of(input int k);
    case (k)
      0: return 32'h0040_0000;
      1: return 32'h0100_0000;
      2: return 32'h8000_0000;
      3: return 32'h0000_0000;
      default: return 32'h7000_0000;
    endcase
  endfunction

  function automatic logic [31:0] off_of(input int k);
    case (k)
      0: return 32'h0;
      1: return 32'h1000;
      2: return 32'h0ABC;
      3: return 32'h1FFC;
      4: return 32'h2000;
      5: return 32'h1_0000;
      6: return 32'h1_0004;
      7: return 32'h40_0000;
      8: return 32'h40_0123;
      9: return 32'h7F_FFFC;
      default: return 32'h80_0000;
    endcase
  endfunction

  function automatic logic [7:0] asid_of(input int k);
    case (k)
      0: return 8'h11;
      1: return 8'h22;
      2: return 8'h33;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_mask[i] = '0; m_g[i] = 1'b0; m_asid[i] = '0;
      m_pe[i] = '0; m_po[i] = '0; m_v[i] = '0; m_d[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    check_exp(32'h0000_0010, 8'h00, 1'b0, 2'd2, 32'h0, 1'b0, "R11 zeroed entry hit invalid");
    check_exp(32'h0000_0010, 8'h05, 1'b0, 2'd1, 32'h0, 1'b0, "R11 other asid nomatch");
    check_exp(32'h8000_0000, 8'h00, 1'b1, 2'd1, 32'h0, 1'b0, "R11 high address nomatch");

    write_ent(0, 32'h0040_0000, 32'h0, 1'b0, 8'h11, 32'h0A00_0000, 32'h0B00_0000, 2'b11, 2'b01);
    write_ent(1, 32'h0100_0000, 32'h0001_E000, 1'b1, 8'h00, 32'h3000_0000, 32'h3001_0000, 2'b01, 2'b11);
    write_ent(2, 32'h0040_0000, 32'h0, 1'b1, 8'h22, 32'h5000_0000, 32'h5000_1000, 2'b11, 2'b11);
    write_ent(3, 32'h8000_0000, 32'h007F_E000, 1'b0, 8'h33, 32'h0000_0000, 32'h0400_0000, 2'b10, 2'b10);

    check_exp(32'h0040_0123, 8'h11, 1'b0, 2'd0, 32'h0A00_0123, 1'b1, "R5 R7 even read");
    check_exp(32'h0040_1123, 8'h11, 1'b1, 2'd3, 32'h0, 1'b0, "R6 write clean odd");
    check_exp(32'h0040_1123, 8'h11, 1'b0, 2'd0, 32'h0B00_0123, 1'b0, "R3 R7 odd read");
    check_exp(32'h0040_0123, 8'h22, 1'b0, 2'd0, 32'h5000_0123, 1'b1, "R1 global fallthrough");
    check_exp(32'h0040_1123, 8'h11, 1'b1, 2'd3, 32'h0, 1'b0, "R9 lowest index wins");
    check_exp(32'h0100_8004, 8'h77, 1'b1, 2'd0, 32'h3000_8004, 1'b1, "R2 wide mask even");
    check_exp(32'h0101_0004, 8'h77, 1'b0, 2'd2, 32'h0, 1'b0, "R4 R3 wide odd invalid");
    check_exp(32'h0102_0000, 8'h77, 1'b0, 2'd1, 32'h0, 1'b0, "R2 R8 tag miss");
    check_exp(32'h8040_0010, 8'h33, 1'b1, 2'd0, 32'h0400_0010, 1'b1, "R5 bit22 odd write");
    check_exp(32'h8040_0010, 8'h34, 1'b0, 2'd1, 32'h0, 1'b0, "R1 asid mismatch");
    check_exp(32'h8000_0010, 8'h33, 1'b0, 2'd2, 32'h0, 1'b0, "R4 even invalid");

    // R10: write visible only after the edge
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'd3; wr_vpn = 32'h8000_0000; wr_mask = 32'h007F_E000;
    wr_g = 1'b0; wr_asid = 8'h44; wr_pe = 32'h0; wr_po = 32'h0400_0000; wr_v = 2'b10; wr_d = 2'b10;
    lk_va = 32'h8000_0010; lk_asid = 8'h44; lk_wr = 1'b0;
    #1;
    compare("R10 before edge old contents", 2'd1, 32'h0, 1'b0);
    @(posedge clk);
    m_asid[3] = 8'h44;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    compare("R10 after edge new contents", 2'd2, 32'h0, 1'b0);
    m_asid[3] = 8'h33;
    write_ent(3, 32'h8000_0000, 32'h007F_E000, 1'b0, 8'h33, 32'h0, 32'h0400_0000, 2'b10, 2'b10);

    // sweep
    for (int b = 0; b < 5; b++)
      for (int o = 0; o < 11; o++)
        for (int a = 0; a < 4; a++)
          for (int w = 0; w < 2; w++)
            check_model(base_of(b) | off_of(o), asid_of(a), w[0], "R1 R2 R3 R4 R5 R6 R7 R8 R9 sweep");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule